// File: doc/BRIEF.md
# Handshake Bus Read Responder

This block is the target side of a fully interlocked, four-phase read transfer on a shared parallel bus. A requester places an address, raises a request and waits for an acknowledge. The responder stores the address, acknowledges, and then waits for the request to be withdrawn. It then releases its acknowledge, reads one word from a local read port, places that word on the data lines and raises ready. The requester takes the word and acknowledges the ready. The responder then drops ready and lets go of the data lines.

The two bus inputs that come from the requester, request and the data-phase acknowledge, arrive without a known phase relationship to the local clock. Each passes through a two-flop synchronizer before the state machine uses it. The acknowledge line is shared. The responder drives it, with its own output enable, only during the address phase. It releases the line before any data is presented, so that in the data phase the requester can use it to answer ready. The local read port has a fixed latency of one clock. Ready does not rise until the fetched word sits in a register of the block.

Top module: `hs_read_responder`

## Requirements
- R1: While reset is held, and after it is released with request low, the acknowledge value, the acknowledge enable, ready, the data enable and the read strobe are all 0.
- R2: A request that goes high just before a rising edge gives acknowledge and acknowledge enable at 1 after the third rising edge, and not before it. The address on the bus at that time is stored.
- R3: Acknowledge stays at 1 while the synchronized request is high. When request is seen low, acknowledge goes to 0 while its enable stays at 1 for exactly one more cycle, and then the enable goes to 0.
- R4: Each transaction raises the read strobe for exactly one cycle, with the stored address on the read address output. This happens in the cycle in which acknowledge is 0 and its enable is still 1.
- R5: Ready and the data enable rise in the same cycle, two cycles after the read strobe. While they are high, the data output holds the word that the read port returned for the stored address and does not change.
- R6: The acknowledge enable and ready are never 1 in the same cycle.
- R7: Ready and the data enable stay at 1 until the synchronized acknowledge input is seen high. Then both go to 0 together.
- R8: After ready falls, a new request is not accepted while the acknowledge input is still high. Once that input is seen low, a pending request is acknowledged.
- R9: While the data enable is 0, the data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req_i | input | 1 | Request from the requester, asynchronous |
| bus_ack_i | input | 1 | Acknowledge from the requester in the data phase, asynchronous |
| bus_addr_i | input | ADDR_W | Address lines of the bus |
| bus_ack_o | output | 1 | Acknowledge value driven by the responder |
| bus_ack_oe_o | output | 1 | Output enable for the acknowledge line |
| bus_rdy_o | output | 1 | Ready, data valid on the bus |
| bus_data_o | output | DATA_W | Data lines value |
| bus_data_oe_o | output | 1 | Output enable for the data lines |
| mem_rd_en_o | output | 1 | Read strobe to the local read port |
| mem_rd_addr_o | output | ADDR_W | Read address to the local read port |
| mem_rd_data_i | input | DATA_W | Word from the read port, one cycle after the strobe |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. Sixteen addresses are few enough that every one of them is read in turn and then again in random order. Each word the memory model returns is a simple arithmetic function of its address, so the bench can tell whether a word came from the wrong address or from a stale read. The narrow setup also keeps each transaction short. This leaves room to vary how long the requester holds its acknowledge, and to raise a new request before the previous acknowledge has been dropped.

// File: rtl/hs_resp_pkg.sv
// Package: shared types for the handshake read responder.
// Assumes: nothing beyond IEEE 1800-2017.
package hs_resp_pkg;

    // Sequencer states of the responder, in transaction order.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for request
        ST_ACK_HI = 3'd1,  // acknowledge driven 1, waiting for request low
        ST_ACK_LO = 3'd2,  // acknowledge driven 0, read strobe issued
        ST_FETCH  = 3'd3,  // line released, read word being registered
        ST_DRIVE  = 3'd4,  // data and ready presented
        ST_DONE   = 3'd5   // ready dropped, waiting for requester ack low
    } resp_state_e;

endpackage

// File: rtl/hs_sync.sv
// Module: hs_sync
// Multi-bit bank of flop-chain synchronizers. Each bit passes through STAGES
// flops and is reset to 0. Assumes the bits are independent level signals.
module hs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: sample the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: move the value one flop along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hs_resp_fsm.sv
// Module: hs_resp_fsm
// Sequencer for the responder. It takes the synchronized request and
// acknowledge inputs and produces the bus control outputs as decodes of a
// registered state. It also gives the datapath its capture and load strobes.
// Assumes: req_s and ack_s are already synchronous to clk.
module hs_resp_fsm
    import hs_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    output logic cap_addr_o,
    output logic rd_en_o,
    output logic load_data_o,
    output logic ack_o,
    output logic ack_oe_o,
    output logic rdy_o,
    output logic data_oe_o
);

    resp_state_e state_q, state_d;

    // Next-state choice for each phase of the transaction.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_s)  state_d = ST_ACK_HI;
            ST_ACK_HI: if (!req_s) state_d = ST_ACK_LO;
            ST_ACK_LO: state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DRIVE;
            ST_DRIVE:  if (ack_s)  state_d = ST_DONE;
            ST_DONE:   if (!ack_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobes for the datapath, taken at the edge that leaves the state.
    always_comb begin
        cap_addr_o  = (state_q == ST_IDLE) && req_s;
        rd_en_o     = (state_q == ST_ACK_LO);
        load_data_o = (state_q == ST_FETCH);
    end

    // Bus controls, decoded from the registered state only.
    always_comb begin
        ack_o     = (state_q == ST_ACK_HI);
        ack_oe_o  = (state_q == ST_ACK_HI) || (state_q == ST_ACK_LO);
        rdy_o     = (state_q == ST_DRIVE);
        data_oe_o = (state_q == ST_DRIVE);
    end

endmodule

// File: rtl/hs_resp_datapath.sv
// Module: hs_resp_datapath
// Address and data registers of the responder. It stores the bus address on
// the capture strobe and the read word on the load strobe. It drives zeros
// on the data output while the data enable is low.
// Assumes: the read port returns its word one cycle after the strobe.
module hs_resp_datapath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_addr_i,
    input  logic              load_data_i,
    input  logic              data_oe_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] bus_data_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Address register, loaded when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)          addr_q <= '0;
        else if (cap_addr_i) addr_q <= bus_addr_i;
    end

    // Data register, loaded with the word returned by the read port.
    always_ff @(posedge clk) begin
        if (!rst_n)           data_q <= '0;
        else if (load_data_i) data_q <= rd_data_i;
    end

    // Output gating: zeros unless the data lines are enabled.
    always_comb begin
        rd_addr_o  = addr_q;
        bus_data_o = data_oe_i ? data_q : '0;
    end

endmodule

// File: rtl/hs_read_responder.sv
// Module: hs_read_responder (top)
// Target side of a four-phase interlocked read transfer. It synchronizes
// request and acknowledge, sequences the handshake and fetches one word per
// transaction from a local read port.
// Assumes: the requester holds the address stable while request is high, and
// the local read port has a latency of one clock.
module hs_read_responder #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_ack_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic              bus_ack_o,
    output logic              bus_ack_oe_o,
    output logic              bus_rdy_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i
);

    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_in;
    logic [N_ASYNC-1:0] sync_out;
    logic               req_s;
    logic               ack_s;
    logic               cap_addr;
    logic               load_data;

    assign async_in = {bus_ack_i, bus_req_i};
    assign req_s    = sync_out[0];
    assign ack_s    = sync_out[1];

    hs_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STGS)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (async_in),
        .q_o   (sync_out)
    );

    hs_resp_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_s       (req_s),
        .ack_s       (ack_s),
        .cap_addr_o  (cap_addr),
        .rd_en_o     (mem_rd_en_o),
        .load_data_o (load_data),
        .ack_o       (bus_ack_o),
        .ack_oe_o    (bus_ack_oe_o),
        .rdy_o       (bus_rdy_o),
        .data_oe_o   (bus_data_oe_o)
    );

    hs_resp_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) dp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_addr_i  (cap_addr),
        .load_data_i (load_data),
        .data_oe_i   (bus_data_oe_o),
        .bus_addr_i  (bus_addr_i),
        .rd_data_i   (mem_rd_data_i),
        .rd_addr_o   (mem_rd_addr_o),
        .bus_data_o  (bus_data_o)
    );

endmodule

// File: rtl/hs_read_responder_chk.sv
// Module: hs_read_responder_chk
// Protocol checker for the responder's ports, bound into every instance.
// Assumes: the same parameters as the instance it is bound to.
module hs_read_responder_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_i,
    input logic              bus_ack_i,
    input logic              bus_ack_o,
    input logic              bus_ack_oe_o,
    input logic              bus_rdy_o,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              bus_data_oe_o,
    input logic              mem_rd_en_o,
    input logic [ADDR_W-1:0] mem_rd_addr_o
);

    // R6: acknowledge enable and ready are never high together.
    a_r6_no_ack_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack_oe_o && bus_rdy_o));

    // R2: acknowledge only rises on a request that was present before.
    a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_o) |-> $past(bus_req_i));

    // R3: when acknowledge falls, its enable is still held for that cycle.
    a_r3_oe_holds_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_o) |-> bus_ack_oe_o);

    // R3: the enable is released only after a cycle with acknowledge at 0.
    a_r3_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_oe_o) |-> !$past(bus_ack_o));

    // R4: the read strobe lasts a single cycle.
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    // R4: the read address holds from the strobe until ready rises.
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_en_o) |-> $stable(mem_rd_addr_o));

    // R5: ready rises two cycles after the read strobe.
    a_r5_rdy_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdy_o) |-> $past(mem_rd_en_o, 2));

    // R5: ready and the data enable rise together, data stable while ready.
    a_r5_oe_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdy_o) |-> $rose(bus_data_oe_o));
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdy_o && $past(bus_rdy_o)) |-> $stable(bus_data_o));

    // R7: ready falls only after the requester acknowledged it.
    a_r7_rdy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdy_o) |-> ($past(bus_ack_i) && !bus_data_oe_o));

    // R9: data lines carry zeros while not enabled.
    a_r9_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_data_oe_o |-> (bus_data_o == '0));

endmodule

bind hs_read_responder hs_read_responder_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req_i     (bus_req_i),
    .bus_ack_i     (bus_ack_i),
    .bus_ack_o     (bus_ack_o),
    .bus_ack_oe_o  (bus_ack_oe_o),
    .bus_rdy_o     (bus_rdy_o),
    .bus_data_o    (bus_data_o),
    .bus_data_oe_o (bus_data_oe_o),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_rd_addr_o (mem_rd_addr_o)
);

// File: tb/hs_read_responder_tb.sv
module hs_read_responder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WAIT_MAX = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          ack_in = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ack_o, ack_oe, rdy, data_oe, rd_en;
    logic [DW-1:0] data_o;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_q = '0;

    int total = 0;
    int bad = 0;
    int rd_count = 0;
    logic [AW-1:0] rd_last = '0;
    int overlap_err = 0;
    int pair_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hs_read_responder #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req_i     (req),
        .bus_ack_i     (ack_in),
        .bus_addr_i    (addr),
        .bus_ack_o     (ack_o),
        .bus_ack_oe_o  (ack_oe),
        .bus_rdy_o     (rdy),
        .bus_data_o    (data_o),
        .bus_data_oe_o (data_oe),
        .mem_rd_en_o   (rd_en),
        .mem_rd_addr_o (rd_addr),
        .mem_rd_data_i (mem_q)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = DW'(a) * DW'(29) + DW'(7);
        return v ^ DW'(8'h5A);
    endfunction

    // Memory model with one cycle of read latency; strobe bookkeeping.
    always @(posedge clk) begin
        if (rd_en) begin
            mem_q    <= word_of(rd_addr);
            rd_count <= rd_count + 1;
            rd_last  <= rd_addr;
        end
    end

    // Continuous monitor for R6 and R5 pairing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_oe && rdy) overlap_err++;
            if (rdy != data_oe) pair_err++;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One read as the requester; req_pending means request is already high.
    task automatic do_read(input logic [AW-1:0] a, input int hold, input bit req_pending);
        int n;
        int rc0;
        rc0 = rd_count;
        if (!req_pending) begin
            @(negedge clk);
            addr = a;
            req  = 1'b1;
            n = 0;
            while (!ack_o && n < WAIT_MAX) begin @(negedge clk); n++; end
            check(n == 3, "R2 ack latency", n, 3);
        end else begin
            n = 0;
            while (!ack_o && n < WAIT_MAX) begin @(negedge clk); n++; end
            check(ack_o == 1'b1, "R8 pending request acknowledged", ack_o, 1);
        end
        check(ack_oe == 1'b1, "R2 ack enable", ack_oe, 1);
        repeat (hold) @(negedge clk);
        check(ack_o == 1'b1, "R3 ack held while request high", ack_o, 1);
        req = 1'b0;
        n = 0;
        while (ack_o && n < WAIT_MAX) begin @(negedge clk); n++; end
        check(ack_oe == 1'b1, "R3 enable held one cycle", ack_oe, 1);
        check(rd_count == rc0, "R4 strobe in ack-low cycle", rd_count - rc0, 0);
        @(negedge clk);
        check(ack_oe == 1'b0, "R3 enable released", ack_oe, 0);
        check(rd_count == rc0 + 1, "R4 one strobe", rd_count - rc0, 1);
        check(rd_last == a, "R4 strobe address", rd_last, a);
        n = 0;
        while (!rdy && n < WAIT_MAX) begin @(negedge clk); n++; end
        check(n == 1, "R5 ready two cycles after strobe", n, 1);
        check(data_oe == 1'b1, "R5 data enable with ready", data_oe, 1);
        check(data_o == word_of(a), "R5 data word", data_o, word_of(a));
        repeat (hold) @(negedge clk);
        check(rdy == 1'b1 && data_o == word_of(a), "R7 ready held", rdy, 1);
        ack_in = 1'b1;
        n = 0;
        while (rdy && n < WAIT_MAX) begin @(negedge clk); n++; end
        check(n == 3, "R7 ready drop latency", n, 3);
        check(data_oe == 1'b0 && data_o == '0, "R9 data released", data_o, 0);
        check(rd_count == rc0 + 1, "R4 no extra strobe", rd_count - rc0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({ack_o, ack_oe, rdy, data_oe, rd_en} == 5'b0, "R1 reset outputs",
              {ack_o, ack_oe, rdy, data_oe, rd_en}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({ack_o, ack_oe, rdy, data_oe, rd_en} == 5'b0, "R1 idle outputs",
              {ack_o, ack_oe, rdy, data_oe, rd_en}, 0);
        check(data_o == '0, "R9 idle data zero", data_o, 0);

        // Sweep every address in order.
        for (int i = 0; i < (1 << AW); i++) begin
            do_read(AW'(i), i % 3, 1'b0);
            @(negedge clk);
            ack_in = 1'b0;
            repeat (3) @(negedge clk);
        end

        // Random order with varied hold times.
        for (int i = 0; i < 24; i++) begin
            do_read(AW'($urandom_range((1 << AW) - 1)), int'($urandom_range(4)), 1'b0);
            @(negedge clk);
            ack_in = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R8: new request raised while the data-phase acknowledge is still high.
        do_read(AW'(5), 1, 1'b0);
        addr = AW'(11);
        req  = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(ack_o == 1'b0 && ack_oe == 1'b0, "R8 request held off", ack_o, 0);
        end
        ack_in = 1'b0;
        do_read(AW'(11), 2, 1'b1);
        @(negedge clk);
        ack_in = 1'b0;
        repeat (4) @(negedge clk);

        check(overlap_err == 0, "R6 ack enable with ready", overlap_err, 0);
        check(pair_err == 0, "R5 ready and data enable paired", pair_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule